// File: doc/BRIEF.md
# Nested-Loop Pulse State Sequencer

The block plays a pulse program held in a small internal program memory. Each program entry does one of four things. It can drive a 24-bit output word for a programmed number of enabled clock ticks. It can open a repeated sub-sequence with a repeat count. It can close the innermost open sub-sequence. It can end the run. Sub-sequences nest, and play is strictly depth-first. When a body has repeated its programmed number of times, play continues with the entry that follows the closing entry. A hardware stack of return addresses and remaining-repeat counters does this, so repeated bodies are never unrolled in memory.

Software or a loader fills the memory through a simple write port while the block is idle, then pulses start. The output word is a register. It reads zero whenever the block is not playing. A busy flag covers the run. A one-cycle done pulse marks a normal end or an abort. A sticky error flag reports a loop stack overflow or underflow, and playback halts when it is set. An external clock enable sets the tick rate for state durations.

Top module: `nest_seq`

## Requirements
- R1: An entry word is `{op[1:0], arg[15:0], word[23:0]}` with op 0 = state, 1 = loop open, 2 = loop close, 3 = stop. A state entry drives `word` on `out_o` for exactly `arg` clock cycles in which `tick_en_i` is high. An `arg` of 0 behaves as 1, and an all-zero word drives all 24 output bits to zero.
- R2: A state that follows a state takes over on the same clock edge on which the earlier one ends, with no gap cycle. Each loop-open, loop-close or stop entry that executes takes exactly one clock cycle, and during that cycle the previous output word is held.
- R3: A loop-open entry with `arg` = n > 0 plays its body n times. Inner loops play completely on each pass of an outer loop (depth-first). After the last pass, play continues at the entry following the matching loop close.
- R4: A loop-open entry with `arg` = 0 skips its body. It scans forward one entry per clock cycle, counting nested open/close pairs, up to and including the matching close, and play then continues after that close.
- R5: The loop stack holds 4 levels. Opening a fifth level sets `err_o`, clears `out_o`, drops `busy_o` and gives no done pulse.
- R6: A loop close with no open loop has the same effect as an overflow: error set, output cleared, busy dropped, no done pulse.
- R7: A stop entry clears `out_o`, drops `busy_o` and pulses `done_o` for exactly one cycle on the next clock edge.
- R8: `abort_i` high during a run ends it on that edge, with the output cleared, busy dropped and a one-cycle done pulse.
- R9: After reset `out_o`, `busy_o`, `done_o` and `err_o` are 0. `err_o` stays set until the next start, which clears it. `start_i` is ignored while busy. The first entry takes effect on the start edge itself.
- R10: While a state is playing, cycles with `tick_en_i` low do not count toward its duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Duration tick enable |
| wr_en_i | input | 1 | Program memory write strobe |
| wr_addr_i | input | 6 | Program memory write address |
| wr_data_i | input | 42 | Program entry to write |
| start_i | input | 1 | Start playback at entry 0 |
| abort_i | input | 1 | Abort a running program |
| out_o | output | 24 | Output word |
| busy_o | output | 1 | Program is playing |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky loop stack error |

## Verification
The hardest situation to reach is a zero-count loop whose body contains further loops. The scanner then has to track its own nesting depth while the real stack stays untouched, and it must resume at exactly the right entry. Random structured programs bring this about often, because they use repeat counts from 0 to 3 and nest up to three levels. Every clock cycle of the output is compared with a cycle-exact trace that a bench interpreter produces. Directed programs cover stack overflow and underflow, duration 0, gated ticks and abort.

// File: rtl/nest_seq_pkg.sv
package nest_seq_pkg;
  localparam int WORD_W = 24;
  localparam int ARG_W  = 16;
  localparam int OP_W   = 2;
  localparam int INSTR_W = OP_W + ARG_W + WORD_W;

  typedef enum logic [OP_W-1:0] {
    OP_STATE = 2'd0,
    OP_OPEN  = 2'd1,
    OP_CLOSE = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [ARG_W-1:0]  arg;
    logic [WORD_W-1:0] word;
  } instr_t;
endpackage

// File: rtl/seq_prog_mem.sv
module seq_prog_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 42
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/seq_loop_stack.sv
module seq_loop_stack #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              dec_i,
  input  logic [ADDR_W-1:0] push_ret_i,
  input  logic [CNT_W-1:0]  push_cnt_i,
  output logic [ADDR_W-1:0] top_ret_o,
  output logic [CNT_W-1:0]  top_cnt_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] ret_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q [DEPTH];
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   top_idx;

  assign top_idx   = (sp_q == '0) ? '0 : sp_q - 1'b1;
  assign full_o    = (sp_q == SP_W'(DEPTH));
  assign empty_o   = (sp_q == '0);
  assign top_ret_o = ret_q[top_idx];
  assign top_cnt_o = cnt_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (clr_i) begin
      sp_q <= '0;
    end else if (push_i) begin
      sp_q <= sp_q + 1'b1;
    end else if (pop_i) begin
      sp_q <= sp_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ret_q[g] <= '0;
        cnt_q[g] <= '0;
      end else if (push_i && sp_q == SP_W'(g)) begin
        ret_q[g] <= push_ret_i;
        cnt_q[g] <= push_cnt_i;
      end else if (dec_i && top_idx == SP_W'(g)) begin
        cnt_q[g] <= cnt_q[g] - 1'b1;
      end
    end
  end

  a_r5_sp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SP_W'(DEPTH));
  a_r5_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r6_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || dec_i) |-> !empty_o);
endmodule

// File: rtl/nest_seq.sv
module nest_seq
  import nest_seq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int STACK_DEP = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_en_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [INSTR_W-1:0]   wr_data_i,
  input  logic                 start_i,
  input  logic                 abort_i,
  output logic [WORD_W-1:0]    out_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o
);
  localparam int SD_W = ADDR_W + 1;

  logic              busy_q, busy_n, active_q, active_n, skip_q, skip_n;
  logic              done_q, done_n, err_q, err_n;
  logic [ADDR_W-1:0] pc_q, pc_n;
  logic [SD_W-1:0]   sdep_q, sdep_n;
  logic [ARG_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] out_q, out_n;

  logic              disp_en;
  logic [ADDR_W-1:0] disp_addr;
  logic [INSTR_W-1:0] raw_a, raw_b;
  instr_t            cur, tgt;

  logic              st_clr, st_push, st_pop, st_dec, st_full, st_empty;
  logic [ADDR_W-1:0] top_ret;
  logic [ARG_W-1:0]  top_cnt;

  seq_prog_mem #(.ADDR_W(ADDR_W), .DATA_W(INSTR_W)) u_mem (
    .clk_i     (clk_i),
    .we_i      (wr_en_i),
    .waddr_i   (wr_addr_i),
    .wdata_i   (wr_data_i),
    .raddr_a_i (pc_q),
    .rdata_a_o (raw_a),
    .raddr_b_i (disp_addr),
    .rdata_b_o (raw_b)
  );

  assign cur = instr_t'(raw_a);
  assign tgt = instr_t'(raw_b);

  seq_loop_stack #(.DEPTH(STACK_DEP), .ADDR_W(ADDR_W), .CNT_W(ARG_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (st_clr),
    .push_i     (st_push),
    .pop_i      (st_pop),
    .dec_i      (st_dec),
    .push_ret_i (pc_q + 1'b1),
    .push_cnt_i (cur.arg),
    .top_ret_o  (top_ret),
    .top_cnt_o  (top_cnt),
    .full_o     (st_full),
    .empty_o    (st_empty)
  );

  always_comb begin
    busy_n = busy_q; active_n = active_q; skip_n = skip_q;
    done_n = 1'b0;   err_n = err_q;       pc_n = pc_q;
    sdep_n = sdep_q; cnt_n = cnt_q;       out_n = out_q;
    disp_en = 1'b0;  disp_addr = pc_q + 1'b1;
    st_clr = 1'b0; st_push = 1'b0; st_pop = 1'b0; st_dec = 1'b0;

    if (!busy_q) begin
      if (start_i) begin
        busy_n = 1'b1; err_n = 1'b0; skip_n = 1'b0; st_clr = 1'b1;
        disp_en = 1'b1; disp_addr = '0;
      end
    end else if (abort_i) begin
      busy_n = 1'b0; active_n = 1'b0; skip_n = 1'b0; out_n = '0; done_n = 1'b1;
    end else if (active_q) begin
      if (tick_en_i) begin
        if (cnt_q <= ARG_W'(1)) disp_en = 1'b1;
        else cnt_n = cnt_q - 1'b1;
      end
    end else if (skip_q) begin
      pc_n = pc_q + 1'b1;
      unique case (cur.op)
        OP_OPEN:  sdep_n = sdep_q + 1'b1;
        OP_CLOSE: begin
          if (sdep_q == SD_W'(1)) begin
            skip_n = 1'b0; disp_en = 1'b1;
          end else sdep_n = sdep_q - 1'b1;
        end
        OP_STOP: begin
          busy_n = 1'b0; skip_n = 1'b0; out_n = '0; done_n = 1'b1;
        end
        default: ;
      endcase
    end else begin
      unique case (cur.op)
        OP_STATE: begin
          disp_en = 1'b1; disp_addr = pc_q;
        end
        OP_OPEN: begin
          if (cur.arg == '0) begin
            skip_n = 1'b1; sdep_n = SD_W'(1); pc_n = pc_q + 1'b1;
          end else if (st_full) begin
            err_n = 1'b1; busy_n = 1'b0; out_n = '0;
          end else begin
            st_push = 1'b1; disp_en = 1'b1;
          end
        end
        OP_CLOSE: begin
          if (st_empty) begin
            err_n = 1'b1; busy_n = 1'b0; out_n = '0;
          end else if (top_cnt > ARG_W'(1)) begin
            st_dec = 1'b1; disp_en = 1'b1; disp_addr = top_ret;
          end else begin
            st_pop = 1'b1; disp_en = 1'b1;
          end
        end
        default: begin
          busy_n = 1'b0; out_n = '0; done_n = 1'b1;
        end
      endcase
    end

    // dispatch: a state target loads on this edge, a control target runs next cycle
    if (disp_en) begin
      pc_n = disp_addr;
      if (tgt.op == OP_STATE) begin
        active_n = 1'b1;
        out_n    = tgt.word;
        cnt_n    = (tgt.arg == '0) ? ARG_W'(1) : tgt.arg;
      end else begin
        active_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; active_q <= 1'b0; skip_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;    pc_q <= '0;
      sdep_q <= '0;   cnt_q <= '0;      out_q <= '0;
    end else begin
      busy_q <= busy_n; active_q <= active_n; skip_q <= skip_n;
      done_q <= done_n; err_q <= err_n;       pc_q <= pc_n;
      sdep_q <= sdep_n; cnt_q <= cnt_n;       out_q <= out_n;
    end
  end

  assign out_o  = out_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_idle_out_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> out_o == '0);
  a_r5_err_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !done_o);
  a_r8_abort_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && abort_i |=> !busy_o && done_o && out_o == '0);
  a_r10_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && active_q && !tick_en_i && !abort_i |=> $stable(out_o) && $stable(cnt_q) && busy_o);
endmodule

// File: tb/sim_nest_seq.sv
module sim_nest_seq;
  localparam int AW = 6;
  localparam int IW = 42;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b1, wr_en = 1'b0, start = 1'b0, abort_s = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [IW-1:0] wr_data = '0;
  logic [23:0]   out_w;
  logic          busy, done, err;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [IW-1:0] prog [64];
  int plen;
  int exp_q [$];
  int exp_err;

  always #4 clk = ~clk;

  nest_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .start_i(start), .abort_i(abort_s),
    .out_o(out_w), .busy_o(busy), .done_o(done), .err_o(err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [IW-1:0] mk(input int op, input int arg, input logic [23:0] w);
    return {op[1:0], arg[15:0], w};
  endfunction

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // expected per-cycle output trace from the requirements
  task automatic model();
    int pc = 0, prev = 0, sp = 0, guard = 0;
    int sret [8];
    int scnt [8];
    exp_q.delete();
    exp_err = 0;
    while (guard < 20000) begin
      int op, arg, w;
      guard++;
      op = int'(prog[pc][41:40]); arg = int'(prog[pc][39:24]); w = int'(prog[pc][23:0]);
      if (op == 0) begin
        int d = (arg == 0) ? 1 : arg;
        for (int k = 0; k < d; k++) exp_q.push_back(w);
        prev = w; pc++;
      end else if (op == 1) begin
        exp_q.push_back(prev);
        if (arg == 0) begin
          int dep = 1, p = pc + 1;
          while (1) begin
            int o2 = int'(prog[p][41:40]);
            exp_q.push_back(prev);
            if (o2 == 1) dep++;
            if (o2 == 2) begin
              dep--;
              if (dep == 0) break;
            end
            p++;
          end
          pc = p + 1;
        end else if (sp == 4) begin
          exp_err = 1; return;
        end else begin
          sret[sp] = pc + 1; scnt[sp] = arg; sp++; pc++;
        end
      end else if (op == 2) begin
        exp_q.push_back(prev);
        if (sp == 0) begin
          exp_err = 1; return;
        end
        if (scnt[sp-1] > 1) begin
          scnt[sp-1]--; pc = sret[sp-1];
        end else begin
          sp--; pc++;
        end
      end else begin
        exp_q.push_back(prev);
        return;
      end
    end
  endtask

  task automatic load();
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = prog[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input string req);
    load();
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < exp_q.size(); i++) begin
      chk(req, out_w, exp_q[i]);
      chk({req, " busy"}, busy, 1);
      @(negedge clk);
    end
    chk({req, " end out (R7)"}, out_w, 0);
    chk({req, " end busy (R7)"}, busy, 0);
    chk({req, " done (R7/R5)"}, done, exp_err ? 0 : 1);
    chk({req, " err (R5/R6)"}, err, exp_err);
    @(negedge clk);
    chk({req, " done single (R7)"}, done, 0);
  endtask

  task automatic gen_random();
    int pos = 0, dep = 0;
    while (pos < 40) begin
      int r = $urandom % 10;
      if (r < 5 || (r < 7 && dep >= 3) || (r >= 7 && dep == 0)) begin
        prog[pos] = mk(0, 1 + ($urandom % 4), 24'($urandom));
      end else if (r < 7) begin
        prog[pos] = mk(1, $urandom % 4, 0); dep++;
      end else begin
        prog[pos] = mk(2, 0, 0); dep--;
      end
      pos++;
    end
    while (dep > 0) begin
      prog[pos] = mk(2, 0, 0); pos++; dep--;
    end
    prog[pos] = mk(3, 0, 0);
    plen = pos + 1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset out", out_w, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R9 reset err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset out", out_w, 0);

    // R1, R2: back-to-back states, duration 0 as 1, zero word
    prog[0] = mk(0, 3, 24'hA5A5A5); prog[1] = mk(0, 0, 24'h123456);
    prog[2] = mk(0, 2, 24'h000000); prog[3] = mk(0, 1, 24'hFFFFFF);
    prog[4] = mk(3, 0, 0); plen = 5;
    run("R1 R2 straight states");

    // R3: nested loops depth-first
    prog[0] = mk(1, 2, 0); prog[1] = mk(0, 1, 24'h000011);
    prog[2] = mk(1, 3, 0); prog[3] = mk(0, 2, 24'h000022); prog[4] = mk(2, 0, 0);
    prog[5] = mk(0, 1, 24'h000033); prog[6] = mk(2, 0, 0);
    prog[7] = mk(0, 1, 24'h000044); prog[8] = mk(3, 0, 0); plen = 9;
    run("R3 nested repeat");

    // R4: zero-count loop with nested loop inside its body
    prog[0] = mk(0, 2, 24'h0000AA); prog[1] = mk(1, 0, 0);
    prog[2] = mk(0, 5, 24'h0000BB); prog[3] = mk(1, 2, 0); prog[4] = mk(0, 1, 24'h0000CC);
    prog[5] = mk(2, 0, 0); prog[6] = mk(2, 0, 0); prog[7] = mk(0, 2, 24'h0000DD);
    prog[8] = mk(3, 0, 0); plen = 9;
    run("R4 zero-count skip");

    // R5: fifth level overflows
    for (int i = 0; i < 5; i++) prog[i] = mk(1, 2, 0);
    prog[5] = mk(0, 1, 24'h000001); prog[6] = mk(3, 0, 0); plen = 7;
    prog[0] = mk(0, 2, 24'h00BEEF);
    for (int i = 1; i < 6; i++) prog[i] = mk(1, 2, 0);
    prog[6] = mk(3, 0, 0); plen = 7;
    run("R5 overflow");
    repeat (3) @(negedge clk);
    chk("R5 err sticky", err, 1);
    chk("R5 out cleared", out_w, 0);

    // R6: close without open, then start clears error (R9)
    prog[0] = mk(0, 1, 24'h000777); prog[1] = mk(2, 0, 0); prog[2] = mk(3, 0, 0); plen = 3;
    run("R6 underflow");
    prog[0] = mk(0, 2, 24'h000888); prog[1] = mk(3, 0, 0); plen = 2;
    load();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 start clears err", err, 0);
    chk("R9 first entry on start edge", out_w, 24'h000888);
    repeat (4) @(negedge clk);

    // R10: gated ticks
    prog[0] = mk(0, 5, 24'h0C0C0C); prog[1] = mk(0, 1, 24'h0D0D0D); prog[2] = mk(3, 0, 0); plen = 3;
    load();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int cnt_en = 0, total = 0;
      while (out_w == 24'h0C0C0C && total < 100) begin
        if (tick_en) cnt_en++;
        total++;
        tick_en = ($urandom % 3) != 0;
        @(negedge clk);
      end
      chk("R10 enabled ticks counted", cnt_en, 5);
      chk("R10 next word", out_w, 24'h0D0D0D);
    end
    tick_en = 1'b1;
    repeat (4) @(negedge clk);

    // R8 abort, R9 start ignored while busy
    prog[0] = mk(0, 50, 24'h0ABCDE); prog[1] = mk(3, 0, 0); plen = 2;
    load();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 start ignored while busy", out_w, 24'h0ABCDE);
    repeat (3) @(negedge clk);
    abort_s = 1'b1;
    @(negedge clk); abort_s = 1'b0;
    chk("R8 abort out", out_w, 0);
    chk("R8 abort busy", busy, 0);
    chk("R8 abort done", done, 1);
    @(negedge clk);
    chk("R8 abort done single", done, 0);

    // random structured programs (R1-style traces under R2 R3 R4)
    for (int t = 0; t < 10; t++) begin
      gen_random();
      run("R3 R4 random program");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule